// File: doc/BRIEF.md
# Indexed Configuration Port for a Multi-Function Peripheral Chip

This block is the configuration register file of a chip that hosts several peripheral functions (disk controller, serial ports, printer port, keyboard). Software reaches it through a two-location bus port. One location holds a register number, and the next location up reads or writes the register that number names. The port is normally locked. A key byte written to the index location opens it, and a second key byte closes it again. While it is closed, the register file cannot be read or changed.

A global select register picks one logical device. Every register number from 0x30 upward then lands in that device's own bank. Each bank holds an activate bit, a 16-bit I/O base, two interrupt numbers, a DMA channel and two mode bytes. Every bank's settings leave the block on dedicated output buses, and the functional devices next to this block take their configuration from there. A fixed chip identifier can be read from a global register.

Top module: `sio_cfg_port`

## Requirements
- R1: After a synchronous active-low reset the port is locked, the index is 0x00, the device select is 0x00, and every bank register is zero, so every device output shows inactive with base, interrupts, DMA and modes at zero.
- R2: While locked, a read of the data location returns 0xFF and a write to it changes no register.
- R3: While locked, only an index write of 0x55 opens the port. Any other index byte is dropped, and a read of the index location returns 0xFF.
- R4: While open, an index write of 0xAA closes the port. All exported device settings are kept.
- R5: While open, an index write of any byte except 0xAA stores that byte as the register number. The index location reads back the stored number, and the stored number survives a close and reopen.
- R6: Register 0x20 always reads 0x40, and writes to it are dropped.
- R7: Register 0x07 holds the device select and reads back the byte written to it. Register numbers 0x30 and above reach only the bank of the selected device.
- R8: Bank registers 0x60 and 0x61 are the high and low bytes of that device's 16-bit base output. For example, 0x03 and 0xF8 give 0x03F8.
- R9: Bank registers 0x70, 0x72 and 0x74 drive the device's primary interrupt, secondary interrupt and DMA outputs, and they read back the full byte.
- R10: Bit 0 of bank register 0x30 is the device's activate output. The other bits of that register are not stored and read as 0.
- R11: Bank registers 0xF0 and 0xF1 are full-byte mode registers, exported and read back.
- R12: Register numbers that are not implemented read 0x00, and writes to them change nothing.
- R13: When the device select is NUM_DEV or more, bank writes reach no device and bank reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_sel_data | input | 1 | 0 selects the index location, 1 selects the data location (index + 1) |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte of the selected location, combinational |
| dev_active | output | NUM_DEV | Activate bit of each device |
| dev_base | output | NUM_DEV*16 | I/O base of each device, device d at bits [16d+15:16d] |
| dev_irq | output | NUM_DEV*8 | Primary interrupt number of each device |
| dev_irq2 | output | NUM_DEV*8 | Secondary interrupt number of each device |
| dev_dma | output | NUM_DEV*8 | DMA channel of each device |
| dev_mode_a | output | NUM_DEV*8 | First mode byte of each device |
| dev_mode_b | output | NUM_DEV*8 | Second mode byte of each device |

## Verification
The assertions check four rules on every cycle:
- The port opens only on the open key and closes only on the close key.
- A locked port reads 0xFF, and the identifier reads 0x40.
- At most one bank takes a write, and no bank takes one while the select is out of range.
- A bank with no write enable holds its settings, and the activate bit follows bit 0 of the byte written.

The bench scenarios cover what needs a history of accesses:
- Bytes dropped while locked are really gone after the port opens.
- Banks are independent of each other.
- Base, interrupt, DMA and mode values reach the correct output slices.
- Settings survive a close.
- A reset in the middle of a run clears everything.

// File: rtl/sio_cfg_pkg.sv
// Shared constants and the per-device configuration record for the
// indexed configuration port. Assumes a byte-wide bus.
package sio_cfg_pkg;

    localparam logic [7:0] KEY_OPEN    = 8'h55;
    localparam logic [7:0] KEY_CLOSE   = 8'hAA;
    localparam logic [7:0] LOCKED_BYTE = 8'hFF;

    // Global register numbers
    localparam logic [7:0] REG_DEVSEL  = 8'h07;
    localparam logic [7:0] REG_IDENT   = 8'h20;

    // Banked register numbers (0x30 and above go to the selected bank)
    localparam logic [7:0] REG_ENABLE  = 8'h30;
    localparam logic [7:0] REG_BASE_HI = 8'h60;
    localparam logic [7:0] REG_BASE_LO = 8'h61;
    localparam logic [7:0] REG_INT_A   = 8'h70;
    localparam logic [7:0] REG_INT_B   = 8'h72;
    localparam logic [7:0] REG_DMA_CH  = 8'h74;
    localparam logic [7:0] REG_MODE_A  = 8'hF0;
    localparam logic [7:0] REG_MODE_B  = 8'hF1;

    typedef struct packed {
        logic        enable;
        logic [15:0] base;
        logic [7:0]  int_a;
        logic [7:0]  int_b;
        logic [7:0]  dma_ch;
        logic [7:0]  mode_a;
        logic [7:0]  mode_b;
    } dev_cfg_t;

endpackage

// File: rtl/sio_key_gate.sv
// Lock state and index register of the configuration port.
// Assumes: idx_wr is a one-cycle strobe for each index-location write.
// While locked, only KEY_OPEN is honoured. While open, KEY_CLOSE locks,
// and any other byte becomes the register number.
module sio_key_gate
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic [7:0] index
);

    // Track the lock state and latch register numbers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
            index    <= 8'h00;
        end else if (idx_wr) begin
            if (!unlocked) begin
                if (wdata == KEY_OPEN) unlocked <= 1'b1;
            end else if (wdata == KEY_CLOSE) begin
                unlocked <= 1'b0;
            end else begin
                index <= wdata;
            end
        end
    end

    // R3: the port opens only after the open key on the index location
    p_open_by_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(idx_wr && wdata == KEY_OPEN));

    // R4: the port closes only after the close key on the index location
    p_close_by_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlocked) |-> $past(idx_wr && wdata == KEY_CLOSE));

    // R3: the index never moves while the port is locked
    p_index_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(index));

endmodule

// File: rtl/sio_dev_bank.sv
// Register bank of one logical device.
// Assumes: we is asserted only for a data write that targets this bank.
// Unknown register numbers are dropped on write and read as zero.
module sio_dev_bank
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output dev_cfg_t   cfg
);

    // Store the written byte into the addressed bank register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            case (idx)
                REG_ENABLE:  cfg.enable      <= wdata[0];
                REG_BASE_HI: cfg.base[15:8]  <= wdata;
                REG_BASE_LO: cfg.base[7:0]   <= wdata;
                REG_INT_A:   cfg.int_a       <= wdata;
                REG_INT_B:   cfg.int_b       <= wdata;
                REG_DMA_CH:  cfg.dma_ch      <= wdata;
                REG_MODE_A:  cfg.mode_a      <= wdata;
                REG_MODE_B:  cfg.mode_b      <= wdata;
                default:     ;
            endcase
        end
    end

    // Return the addressed bank register, zero for unknown numbers
    always_comb begin
        case (idx)
            REG_ENABLE:  rdata = {7'b0, cfg.enable};
            REG_BASE_HI: rdata = cfg.base[15:8];
            REG_BASE_LO: rdata = cfg.base[7:0];
            REG_INT_A:   rdata = cfg.int_a;
            REG_INT_B:   rdata = cfg.int_b;
            REG_DMA_CH:  rdata = cfg.dma_ch;
            REG_MODE_A:  rdata = cfg.mode_a;
            REG_MODE_B:  rdata = cfg.mode_b;
            default:     rdata = 8'h00;
        endcase
    end

    // R2: a bank that was not written keeps every setting
    p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg));

    // R10: the activate output follows bit 0 of the byte written to 0x30
    p_enable_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == REG_ENABLE) |=> cfg.enable == $past(wdata[0]));

endmodule

// File: rtl/sio_cfg_port.sv
// Top of the indexed configuration port.
// Index location (bus_sel_data=0) holds the register number. The data
// location (bus_sel_data=1) accesses it. Register 0x07 selects a logical
// device, and numbers 0x30 and above reach that device's bank. Assumes
// single-cycle write strobes. Reads are combinational and have no side
// effects.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int         NUM_DEV  = 8,
    parameter logic [7:0] IDENT_ID = 8'h40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_sel_data,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    output logic [NUM_DEV-1:0]   dev_active,
    output logic [NUM_DEV*16-1:0] dev_base,
    output logic [NUM_DEV*8-1:0] dev_irq,
    output logic [NUM_DEV*8-1:0] dev_irq2,
    output logic [NUM_DEV*8-1:0] dev_dma,
    output logic [NUM_DEV*8-1:0] dev_mode_a,
    output logic [NUM_DEV*8-1:0] dev_mode_b
);

    localparam logic [7:0] DEV_LIMIT = 8'(NUM_DEV);

    logic               unlocked;
    logic [7:0]         index;
    logic [7:0]         devsel;
    logic               data_wr;
    logic               in_bank;
    logic [NUM_DEV-1:0] bank_we;
    logic [7:0]         bank_rd [NUM_DEV];
    dev_cfg_t           bank_cfg [NUM_DEV];
    logic [7:0]         sel_rd;

    sio_key_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (bus_wr && !bus_sel_data),
        .wdata    (bus_wdata),
        .unlocked (unlocked),
        .index    (index)
    );

    assign data_wr = bus_wr && bus_sel_data && unlocked;
    assign in_bank = (index >= REG_ENABLE);

    // Hold the logical-device select
    always_ff @(posedge clk) begin
        if (!rst_n)                              devsel <= 8'h00;
        else if (data_wr && index == REG_DEVSEL) devsel <= bus_wdata;
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_bank
        assign bank_we[d] = data_wr && in_bank && (devsel == 8'(d));

        sio_dev_bank u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[d]),
            .idx   (index),
            .wdata (bus_wdata),
            .rdata (bank_rd[d]),
            .cfg   (bank_cfg[d])
        );

        assign dev_active[d]         = bank_cfg[d].enable;
        assign dev_base[d*16 +: 16]  = bank_cfg[d].base;
        assign dev_irq[d*8 +: 8]     = bank_cfg[d].int_a;
        assign dev_irq2[d*8 +: 8]    = bank_cfg[d].int_b;
        assign dev_dma[d*8 +: 8]     = bank_cfg[d].dma_ch;
        assign dev_mode_a[d*8 +: 8]  = bank_cfg[d].mode_a;
        assign dev_mode_b[d*8 +: 8]  = bank_cfg[d].mode_b;
    end

    // Pick the read byte of the selected bank, zero when out of range
    always_comb begin
        sel_rd = 8'h00;
        for (int d = 0; d < NUM_DEV; d++) begin
            if (devsel == 8'(d)) sel_rd = bank_rd[d];
        end
    end

    // Drive the read byte for the addressed location
    always_comb begin
        if (!unlocked)          bus_rdata = LOCKED_BYTE;
        else if (!bus_sel_data) bus_rdata = index;
        else if (index == REG_DEVSEL) bus_rdata = devsel;
        else if (index == REG_IDENT)  bus_rdata = IDENT_ID;
        else if (in_bank)       bus_rdata = sel_rd;
        else                    bus_rdata = 8'h00;
    end

    // R7: a data write reaches at most one bank
    p_one_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    // R13: an out-of-range select reaches no bank
    p_no_bank_out_of_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel >= DEV_LIMIT) |-> bank_we == '0);

    // R2: a locked port shows 0xFF on either location
    p_locked_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> bus_rdata == LOCKED_BYTE);

    // R6: the identifier register always reads the fixed ID
    p_ident_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_sel_data && index == REG_IDENT) |-> bus_rdata == IDENT_ID);

    // R2: locked writes never reach any bank
    p_locked_no_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> bank_we == '0);

endmodule

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;

    localparam int NUM_DEV = 8;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  bus_wr = 1'b0;
    logic                  bus_sel_data = 1'b0;
    logic [7:0]            bus_wdata = 8'h00;
    logic [7:0]            bus_rdata;
    logic [NUM_DEV-1:0]    dev_active;
    logic [NUM_DEV*16-1:0] dev_base;
    logic [NUM_DEV*8-1:0]  dev_irq, dev_irq2, dev_dma, dev_mode_a, dev_mode_b;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sio_cfg_port #(.NUM_DEV(NUM_DEV)) i_sio_cfg_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel_data(bus_sel_data),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_active(dev_active),
        .dev_base(dev_base), .dev_irq(dev_irq), .dev_irq2(dev_irq2),
        .dev_dma(dev_dma), .dev_mode_a(dev_mode_a), .dev_mode_b(dev_mode_b)
    );

    // Vector row: {kind[1:0], byte[7:0], requirement number[7:0]}
    localparam logic [1:0] WI = 2'b00;  // write index location
    localparam logic [1:0] WD = 2'b01;  // write data location
    localparam logic [1:0] RI = 2'b10;  // read index location, byte is expected
    localparam logic [1:0] RD = 2'b11;  // read data location, byte is expected
    localparam int NV = 54;
    localparam logic [17:0] VEC [NV] = '{
        {RD, 8'hFF, 8'd2},   // R2 locked data read
        {RI, 8'hFF, 8'd3},   // R3 locked index read
        {WI, 8'h07, 8'd3},   // R3 non-key index byte dropped
        {WD, 8'h05, 8'd2},   // R2 locked data write dropped
        {WI, 8'h55, 8'd3},   // R3 open key
        {RI, 8'h00, 8'd3},   // R3 index still zero
        {RD, 8'h00, 8'd12},  // R12 register 0x00 not implemented
        {WI, 8'h07, 8'd5},   // R5 store index
        {RI, 8'h07, 8'd5},   // R5 index readback
        {RD, 8'h00, 8'd7},   // R7 select still 0, locked write was lost
        {WD, 8'h04, 8'd7},   // R7 select device 4
        {RD, 8'h04, 8'd7},   // R7 select readback
        {WI, 8'h20, 8'd6},
        {RD, 8'h40, 8'd6},   // R6 identifier
        {WD, 8'h12, 8'd6},
        {RD, 8'h40, 8'd6},   // R6 write dropped
        {WI, 8'h60, 8'd8},
        {WD, 8'h03, 8'd8},
        {WI, 8'h61, 8'd8},
        {WD, 8'hF8, 8'd8},
        {RD, 8'hF8, 8'd8},   // R8 base low readback
        {WI, 8'h70, 8'd9},
        {WD, 8'h04, 8'd9},
        {RD, 8'h04, 8'd9},   // R9 primary interrupt
        {WI, 8'h30, 8'd10},
        {WD, 8'hFF, 8'd10},
        {RD, 8'h01, 8'd10},  // R10 only bit 0 stored
        {WI, 8'h07, 8'd7},
        {WD, 8'h05, 8'd7},   // R7 select device 5
        {WI, 8'h60, 8'd7},
        {RD, 8'h00, 8'd7},   // R7 bank 5 separate from bank 4
        {WD, 8'h02, 8'd8},
        {WI, 8'h61, 8'd8},
        {WD, 8'hF8, 8'd8},
        {WI, 8'h70, 8'd9},
        {WD, 8'h03, 8'd9},
        {WI, 8'h74, 8'd9},
        {WD, 8'h02, 8'd9},
        {RD, 8'h02, 8'd9},   // R9 DMA channel
        {WI, 8'h72, 8'd9},
        {WD, 8'h0C, 8'd9},
        {RD, 8'h0C, 8'd9},   // R9 secondary interrupt
        {WI, 8'hF0, 8'd11},
        {WD, 8'hA5, 8'd11},
        {RD, 8'hA5, 8'd11},  // R11 mode A
        {WI, 8'hF1, 8'd11},
        {WD, 8'h5A, 8'd11},
        {RD, 8'h5A, 8'd11},  // R11 mode B
        {WI, 8'h45, 8'd12},
        {WD, 8'h77, 8'd12},
        {RD, 8'h00, 8'd12},  // R12 unimplemented bank register
        {WI, 8'h30, 8'd10},
        {WD, 8'h02, 8'd10},
        {RD, 8'h00, 8'd10}   // R10 bit 1 alone leaves device inactive
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] val);
        @(negedge clk);
        bus_sel_data = sel;
        bus_wdata    = val;
        bus_wr       = 1'b1;
        @(negedge clk);
        bus_wr       = 1'b0;
    endtask

    task automatic bus_read(input logic sel, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_sel_data = sel;
        #2;
        check({24'h0, bus_rdata}, {24'h0, exp}, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic check_cleared(input string req);
        check({24'h0, dev_active}, 32'h0, req);
        check({31'h0, |dev_base}, 32'h0, req);
        check({31'h0, |{dev_irq, dev_irq2, dev_dma, dev_mode_a, dev_mode_b}}, 32'h0, req);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1 reset state
        check_cleared("R1");
        bus_read(1'b1, 8'hFF, "R1 locked after reset");

        for (int i = 0; i < NV; i++) begin
            logic [1:0] kind;
            logic [7:0] val;
            string      tag;
            kind = VEC[i][17:16];
            val  = VEC[i][15:8];
            tag  = $sformatf("R%0d row %0d", VEC[i][7:0], i);
            if (kind[1]) bus_read(kind[0], val, tag);
            else         bus_write(kind[0], val);
        end

        // R8 R9 R10 R11 exported values of device 4 and device 5
        check({16'h0, dev_base[4*16 +: 16]}, 32'h03F8, "R8 dev4 base");
        check({16'h0, dev_base[5*16 +: 16]}, 32'h02F8, "R8 dev5 base");
        check({24'h0, dev_irq[4*8 +: 8]}, 32'h04, "R9 dev4 irq");
        check({24'h0, dev_irq[5*8 +: 8]}, 32'h03, "R9 dev5 irq");
        check({24'h0, dev_dma[5*8 +: 8]}, 32'h02, "R9 dev5 dma");
        check({24'h0, dev_irq2[5*8 +: 8]}, 32'h0C, "R9 dev5 irq2");
        check({24'h0, dev_mode_a[5*8 +: 8]}, 32'hA5, "R11 dev5 mode a");
        check({24'h0, dev_mode_b[5*8 +: 8]}, 32'h5A, "R11 dev5 mode b");
        check({24'h0, dev_active}, 32'h10, "R10 only dev4 active");

        // R13 select beyond the implemented devices
        bus_write(1'b0, 8'h07);
        bus_write(1'b1, 8'h09);
        bus_write(1'b0, 8'h60);
        bus_write(1'b1, 8'h11);
        bus_read(1'b1, 8'h00, "R13 read of absent bank");
        check({16'h0, dev_base[0 +: 16]}, 32'h0, "R13 dev0 base untouched");
        check({16'h0, dev_base[1*16 +: 16]}, 32'h0, "R13 dev1 base untouched");
        check({16'h0, dev_base[4*16 +: 16]}, 32'h03F8, "R13 dev4 base untouched");
        check({16'h0, dev_base[5*16 +: 16]}, 32'h02F8, "R13 dev5 base untouched");
        bus_write(1'b0, 8'h07);
        bus_read(1'b1, 8'h09, "R7 select holds any byte");

        // R4 close the port, settings stay; R2 locked write dropped
        bus_write(1'b0, 8'hAA);
        bus_read(1'b1, 8'hFF, "R4 data read after close");
        bus_read(1'b0, 8'hFF, "R4 index read after close");
        bus_write(1'b1, 8'h00);
        check({16'h0, dev_base[4*16 +: 16]}, 32'h03F8, "R4 base kept");
        check({24'h0, dev_active}, 32'h10, "R4 activate kept");
        bus_write(1'b0, 8'h55);
        bus_read(1'b0, 8'h07, "R5 index kept over close");
        bus_read(1'b1, 8'h09, "R2 select unchanged by locked write");

        // R1 reset during operation
        do_reset();
        check_cleared("R1 mid-run");
        bus_read(1'b1, 8'hFF, "R1 locked after mid-run reset");
        bus_write(1'b0, 8'h55);
        bus_read(1'b0, 8'h00, "R1 index cleared");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule